// File: doc/BRIEF.md
# Decode Operand Hazard and Forwarding Unit

This unit sits beside the decode stage of an in-order five-stage pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the two source register indices of the instruction in decode with the destinations of the instructions further down the pipe. For each operand it either supplies the newest result, taken from a later stage, or raises a stall that holds decode until the dependency is gone.

Four forwarding sources exist: the execute stage, the memory stage, the writeback stage, and a one-entry buffer that keeps the register-file write made in the previous cycle. The buffer is there because the register file returns an undefined value when a register is read in the same cycle it is written. The read data presented to this unit therefore never reflects the write made in the previous cycle. Each source has its own enable parameter. Every instruction in execute and memory carries a flag that says whether its result already exists. An instruction whose result does not exist yet cannot be forwarded, and decode waits for it.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An operand whose use flag is low never causes a stall, and its output equals the register-file read value for that operand.
- R2: An operand with index 0 never causes a stall and always outputs zero, whatever any stage is writing.
- R3: A stage is a producer only when its valid and register-write inputs are both high. Otherwise a matching destination is ignored and the register-file value is output.
- R4: When the newest producer of a used operand is in execute, its ready flag is high and execute forwarding is enabled, the operand outputs the execute result with no stall.
- R5: When the newest producer of a used operand is in execute and its ready flag is low, decode stalls.
- R6: When the newest producer is in memory, the memory result is forwarded if the memory ready flag is high and memory forwarding is enabled. If the memory ready flag is low, decode stalls.
- R7: When the newest producer is the instruction writing the register file this cycle (writeback), its result is forwarded if writeback forwarding is enabled.
- R8: A register-file write made in cycle N (writeback valid and write high, destination not 0) is forwarded in cycle N+1 from the write buffer if buffer forwarding is enabled and no newer stage matches.
- R9: When several sources match the same operand, only the newest decides the outcome, in this order: execute, memory, writeback, buffer. A not-ready newer match stalls even if an older match is ready.
- R10: When the newest matching source has its forwarding disabled, decode stalls.
- R11: The stall output is high when either operand needs a stall. Each operand selects its own source on its own.
- R12: Reset empties the write buffer, so a write presented while reset is asserted is never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs1_idx | input | AW | Decode operand A register index |
| rs1_used | input | 1 | Decode instruction reads operand A |
| rs2_idx | input | AW | Decode operand B register index |
| rs2_used | input | 1 | Decode instruction reads operand B |
| rf_rs1 | input | XLEN | Register-file read value for operand A |
| rf_rs2 | input | XLEN | Register-file read value for operand B |
| ex_vld | input | 1 | Execute stage holds a valid instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_rd | input | AW | Execute destination index |
| ex_rdy | input | 1 | Execute result already available |
| ex_res | input | XLEN | Execute result |
| mem_vld | input | 1 | Memory stage holds a valid instruction |
| mem_wr | input | 1 | Memory instruction writes a register |
| mem_rd | input | AW | Memory destination index |
| mem_rdy | input | 1 | Memory result already available |
| mem_res | input | XLEN | Memory result |
| wb_vld | input | 1 | Writeback stage holds a valid instruction |
| wb_wr | input | 1 | Writeback writes the register file this cycle |
| wb_rd | input | AW | Writeback destination index |
| wb_res | input | XLEN | Writeback result |
| opa_val | output | XLEN | Resolved operand A value |
| opb_val | output | XLEN | Resolved operand B value |
| dec_stall | output | 1 | Hold the decode stage |

## Verification
The hardest case to reach is the buffer path of R8, together with its interaction with reset in R12. The only way to fill the buffer is a writeback write made one cycle earlier. The stimulus therefore arranges a two-cycle sequence: a writeback write to a register nothing else touches, followed by a decode read of that register with every stage cleared. The same pattern is repeated with the write presented during reset, to show that the buffer stays empty. A second instance, built with every forwarding path disabled, runs the same stimulus. On that instance, each match that the first instance forwards must stall instead.

// File: rtl/hzfwd_pkg.sv
package hzfwd_pkg;

  typedef enum logic [2:0] {
    SRC_RF   = 3'd0,
    SRC_ZERO = 3'd1,
    SRC_EX   = 3'd2,
    SRC_MEM  = 3'd3,
    SRC_WB   = 3'd4,
    SRC_BUF  = 3'd5
  } fwd_src_e;

endpackage

// File: rtl/hzfwd_wrbuf.sv
module hzfwd_wrbuf #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_rd,
  input  logic [XLEN-1:0] wr_data,
  output logic            buf_vld,
  output logic [AW-1:0]   buf_rd,
  output logic [XLEN-1:0] buf_data
);

  // keeps the register-file write of the previous cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_vld  <= 1'b0;
      buf_rd   <= '0;
      buf_data <= '0;
    end else begin
      buf_vld <= wr_en && (wr_rd != '0);
      if (wr_en) begin
        buf_rd   <= wr_rd;
        buf_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/hzfwd_srcsel.sv
module hzfwd_srcsel
  import hzfwd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int AW     = 5,
  parameter bit EN_EX  = 1'b1,
  parameter bit EN_MEM = 1'b1,
  parameter bit EN_WB  = 1'b1,
  parameter bit EN_BUF = 1'b1
) (
  input  logic [AW-1:0]   idx,
  input  logic            used,
  input  logic [XLEN-1:0] rf_val,
  input  logic            ex_prod,
  input  logic [AW-1:0]   ex_rd,
  input  logic            ex_rdy,
  input  logic [XLEN-1:0] ex_res,
  input  logic            mem_prod,
  input  logic [AW-1:0]   mem_rd,
  input  logic            mem_rdy,
  input  logic [XLEN-1:0] mem_res,
  input  logic            wb_prod,
  input  logic [AW-1:0]   wb_rd,
  input  logic [XLEN-1:0] wb_res,
  input  logic            buf_prod,
  input  logic [AW-1:0]   buf_rd,
  input  logic [XLEN-1:0] buf_res,
  output logic [XLEN-1:0] val,
  output logic            stall
);

  function automatic logic hits(input logic prod, input logic [AW-1:0] rd,
                                input logic [AW-1:0] want);
    return prod && (rd == want);
  endfunction

  logic     live;
  logic     hit_ex, hit_mem, hit_wb, hit_buf;
  fwd_src_e src;

  assign live    = used && (idx != '0);
  assign hit_ex  = live && hits(ex_prod,  ex_rd,  idx);
  assign hit_mem = live && hits(mem_prod, mem_rd, idx);
  assign hit_wb  = live && hits(wb_prod,  wb_rd,  idx);
  assign hit_buf = live && hits(buf_prod, buf_rd, idx);

  // newest matching source decides; a source that cannot deliver stalls
  always_comb begin
    src   = SRC_RF;
    stall = 1'b0;
    if (idx == '0) begin
      src = SRC_ZERO;
    end else if (hit_ex) begin
      if (EN_EX && ex_rdy) src = SRC_EX;
      else                 stall = 1'b1;
    end else if (hit_mem) begin
      if (EN_MEM && mem_rdy) src = SRC_MEM;
      else                   stall = 1'b1;
    end else if (hit_wb) begin
      if (EN_WB) src = SRC_WB;
      else       stall = 1'b1;
    end else if (hit_buf) begin
      if (EN_BUF) src = SRC_BUF;
      else        stall = 1'b1;
    end
  end

  always_comb begin
    case (src)
      SRC_ZERO: val = '0;
      SRC_EX:   val = ex_res;
      SRC_MEM:  val = mem_res;
      SRC_WB:   val = wb_res;
      SRC_BUF:  val = buf_res;
      default:  val = rf_val;
    endcase
  end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int XLEN       = 32,
  parameter int AW         = 5,
  parameter bit EN_EX_FWD  = 1'b1,
  parameter bit EN_MEM_FWD = 1'b1,
  parameter bit EN_WB_FWD  = 1'b1,
  parameter bit EN_BUF_FWD = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rs1_idx,
  input  logic            rs1_used,
  input  logic [AW-1:0]   rs2_idx,
  input  logic            rs2_used,
  input  logic [XLEN-1:0] rf_rs1,
  input  logic [XLEN-1:0] rf_rs2,
  input  logic            ex_vld,
  input  logic            ex_wr,
  input  logic [AW-1:0]   ex_rd,
  input  logic            ex_rdy,
  input  logic [XLEN-1:0] ex_res,
  input  logic            mem_vld,
  input  logic            mem_wr,
  input  logic [AW-1:0]   mem_rd,
  input  logic            mem_rdy,
  input  logic [XLEN-1:0] mem_res,
  input  logic            wb_vld,
  input  logic            wb_wr,
  input  logic [AW-1:0]   wb_rd,
  input  logic [XLEN-1:0] wb_res,
  output logic [XLEN-1:0] opa_val,
  output logic [XLEN-1:0] opb_val,
  output logic            dec_stall
);

  localparam int NOPND = 2;

  logic            ex_prod, mem_prod, wb_prod;
  logic            buf_vld;
  logic [AW-1:0]   buf_rd;
  logic [XLEN-1:0] buf_data;

  logic [AW-1:0]   opnd_idx  [NOPND];
  logic            opnd_used [NOPND];
  logic [XLEN-1:0] opnd_rf   [NOPND];
  logic [XLEN-1:0] opnd_val  [NOPND];
  logic [NOPND-1:0] opnd_stall;

  assign ex_prod  = ex_vld  && ex_wr;
  assign mem_prod = mem_vld && mem_wr;
  assign wb_prod  = wb_vld  && wb_wr;

  assign opnd_idx[0]  = rs1_idx;
  assign opnd_idx[1]  = rs2_idx;
  assign opnd_used[0] = rs1_used;
  assign opnd_used[1] = rs2_used;
  assign opnd_rf[0]   = rf_rs1;
  assign opnd_rf[1]   = rf_rs2;

  hzfwd_wrbuf #(.XLEN(XLEN), .AW(AW)) u_wrbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wb_prod),
    .wr_rd    (wb_rd),
    .wr_data  (wb_res),
    .buf_vld  (buf_vld),
    .buf_rd   (buf_rd),
    .buf_data (buf_data)
  );

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    hzfwd_srcsel #(
      .XLEN(XLEN), .AW(AW),
      .EN_EX(EN_EX_FWD), .EN_MEM(EN_MEM_FWD),
      .EN_WB(EN_WB_FWD), .EN_BUF(EN_BUF_FWD)
    ) u_sel (
      .idx      (opnd_idx[g]),
      .used     (opnd_used[g]),
      .rf_val   (opnd_rf[g]),
      .ex_prod  (ex_prod),
      .ex_rd    (ex_rd),
      .ex_rdy   (ex_rdy),
      .ex_res   (ex_res),
      .mem_prod (mem_prod),
      .mem_rd   (mem_rd),
      .mem_rdy  (mem_rdy),
      .mem_res  (mem_res),
      .wb_prod  (wb_prod),
      .wb_rd    (wb_rd),
      .wb_res   (wb_res),
      .buf_prod (buf_vld),
      .buf_rd   (buf_rd),
      .buf_res  (buf_data),
      .val      (opnd_val[g]),
      .stall    (opnd_stall[g])
    );
  end

  assign opa_val   = opnd_val[0];
  assign opb_val   = opnd_val[1];
  assign dec_stall = |opnd_stall;

endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int XLEN       = 32,
  parameter int AW         = 5,
  parameter bit EN_EX_FWD  = 1'b1,
  parameter bit EN_BUF_FWD = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   rs1_idx,
  input logic            rs1_used,
  input logic [XLEN-1:0] rf_rs1,
  input logic            ex_vld,
  input logic            ex_wr,
  input logic [AW-1:0]   ex_rd,
  input logic            ex_rdy,
  input logic [XLEN-1:0] ex_res,
  input logic            mem_vld,
  input logic            mem_wr,
  input logic [AW-1:0]   mem_rd,
  input logic            wb_vld,
  input logic            wb_wr,
  input logic [AW-1:0]   wb_rd,
  input logic [XLEN-1:0] wb_res,
  input logic [XLEN-1:0] opa_val,
  input logic            dec_stall
);

  logic ex_match, mem_match, wb_match;
  assign ex_match  = ex_vld  && ex_wr  && (ex_rd  == rs1_idx);
  assign mem_match = mem_vld && mem_wr && (mem_rd == rs1_idx);
  assign wb_match  = wb_vld  && wb_wr  && (wb_rd  == rs1_idx);

  assert_unused_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rs1_used && rs1_idx != '0) |-> (opa_val == rf_rs1));

  assert_x0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1_idx == '0) |-> (opa_val == '0));

  assert_ex_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (EN_EX_FWD && rs1_used && rs1_idx != '0 && ex_match && ex_rdy)
      |-> (opa_val == ex_res));

  assert_ex_wait_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1_used && rs1_idx != '0 && ex_match && !ex_rdy) |-> dec_stall);

  assert_buf_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (EN_BUF_FWD && $past(rst_n) && $past(wb_vld && wb_wr) && $past(wb_rd) != '0
      && rs1_used && rs1_idx == $past(wb_rd) && !ex_match && !mem_match && !wb_match)
      |-> (opa_val == $past(wb_res)));

  assert_disabled_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!EN_EX_FWD && rs1_used && rs1_idx != '0 && ex_match) |-> dec_stall);

endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(
  .XLEN(XLEN), .AW(AW), .EN_EX_FWD(EN_EX_FWD), .EN_BUF_FWD(EN_BUF_FWD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rs1_idx(rs1_idx), .rs1_used(rs1_used), .rf_rs1(rf_rs1),
  .ex_vld(ex_vld), .ex_wr(ex_wr), .ex_rd(ex_rd), .ex_rdy(ex_rdy), .ex_res(ex_res),
  .mem_vld(mem_vld), .mem_wr(mem_wr), .mem_rd(mem_rd),
  .wb_vld(wb_vld), .wb_wr(wb_wr), .wb_rd(wb_rd), .wb_res(wb_res),
  .opa_val(opa_val), .dec_stall(dec_stall)
);

// File: tb/sim_hazard_fwd_unit.sv
module sim_hazard_fwd_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  rs1_idx, rs2_idx, ex_rd, mem_rd, wb_rd;
  logic        rs1_used, rs2_used, ex_vld, ex_wr, ex_rdy, mem_vld, mem_wr, mem_rdy, wb_vld, wb_wr;
  logic [31:0] rf_rs1, rf_rs2, ex_res, mem_res, wb_res;
  logic [31:0] a0, b0, a1, b1;
  logic        s0, s1;

  hazard_fwd_unit u0 (
    .clk(clk), .rst_n(rst_n), .rs1_idx(rs1_idx), .rs1_used(rs1_used),
    .rs2_idx(rs2_idx), .rs2_used(rs2_used), .rf_rs1(rf_rs1), .rf_rs2(rf_rs2),
    .ex_vld(ex_vld), .ex_wr(ex_wr), .ex_rd(ex_rd), .ex_rdy(ex_rdy), .ex_res(ex_res),
    .mem_vld(mem_vld), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rdy(mem_rdy), .mem_res(mem_res),
    .wb_vld(wb_vld), .wb_wr(wb_wr), .wb_rd(wb_rd), .wb_res(wb_res),
    .opa_val(a0), .opb_val(b0), .dec_stall(s0));

  hazard_fwd_unit #(.EN_EX_FWD(1'b0), .EN_MEM_FWD(1'b0), .EN_WB_FWD(1'b0), .EN_BUF_FWD(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .rs1_idx(rs1_idx), .rs1_used(rs1_used),
    .rs2_idx(rs2_idx), .rs2_used(rs2_used), .rf_rs1(rf_rs1), .rf_rs2(rf_rs2),
    .ex_vld(ex_vld), .ex_wr(ex_wr), .ex_rd(ex_rd), .ex_rdy(ex_rdy), .ex_res(ex_res),
    .mem_vld(mem_vld), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_rdy(mem_rdy), .mem_res(mem_res),
    .wb_vld(wb_vld), .wb_wr(wb_wr), .wb_rd(wb_rd), .wb_res(wb_res),
    .opa_val(a1), .opb_val(b1), .dec_stall(s1));

  typedef struct {
    string       tag;
    logic [31:0] ea0, eb0, ea1, eb1;
    logic        es0, es1;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench copy of last cycle's register-file write
  logic        bm_v = 1'b0;
  logic [4:0]  bm_rd = '0;
  logic [31:0] bm_d = '0;

  function automatic void predict(input logic [4:0] idx, input logic used,
                                  input logic [31:0] rf, input bit en,
                                  output logic [31:0] v, output logic st);
    st = 1'b0;
    v  = rf;
    if (idx == 5'd0) begin v = '0; return; end
    if (!used) return;
    for (int k = 0; k < 4; k++) begin
      logic p; logic [4:0] d; logic [31:0] r; logic ok;
      case (k)
        0: begin p = ex_vld && ex_wr;   d = ex_rd;  r = ex_res;  ok = ex_rdy;  end
        1: begin p = mem_vld && mem_wr; d = mem_rd; r = mem_res; ok = mem_rdy; end
        2: begin p = wb_vld && wb_wr;   d = wb_rd;  r = wb_res;  ok = 1'b1;    end
        default: begin p = bm_v; d = bm_rd; r = bm_d; ok = 1'b1; end
      endcase
      if (p && d == idx) begin
        if (en && ok) v = r;
        else          st = 1'b1;
        return;
      end
    end
  endfunction

  task automatic clr();
    rs1_idx = 5'd1; rs1_used = 1'b1; rs2_idx = 5'd2; rs2_used = 1'b1;
    rf_rs1 = 32'h1111_0001; rf_rs2 = 32'h2222_0002;
    ex_vld = 0; ex_wr = 0; ex_rd = 0; ex_rdy = 0; ex_res = 32'hE0E0_0000;
    mem_vld = 0; mem_wr = 0; mem_rd = 0; mem_rdy = 0; mem_res = 32'hA0A0_0000;
    wb_vld = 0; wb_wr = 0; wb_rd = 0; wb_res = 32'hB0B0_0000;
  endtask

  task automatic set_ex(input logic [4:0] rd, input logic rdy, input logic [31:0] r);
    ex_vld = 1; ex_wr = 1; ex_rd = rd; ex_rdy = rdy; ex_res = r;
  endtask
  task automatic set_mem(input logic [4:0] rd, input logic rdy, input logic [31:0] r);
    mem_vld = 1; mem_wr = 1; mem_rd = rd; mem_rdy = rdy; mem_res = r;
  endtask
  task automatic set_wb(input logic [4:0] rd, input logic [31:0] r);
    wb_vld = 1; wb_wr = 1; wb_rd = rd; wb_res = r;
  endtask

  // driver: called right after a falling edge with stimulus applied
  task automatic step(input string tag);
    exp_t e;
    logic sa, sb;
    e.tag = tag;
    predict(rs1_idx, rs1_used, rf_rs1, 1'b1, e.ea0, sa);
    predict(rs2_idx, rs2_used, rf_rs2, 1'b1, e.eb0, sb);
    e.es0 = sa | sb;
    predict(rs1_idx, rs1_used, rf_rs1, 1'b0, e.ea1, sa);
    predict(rs2_idx, rs2_used, rf_rs2, 1'b0, e.eb1, sb);
    e.es1 = sa | sb;
    q.push_back(e);
    @(posedge clk);
    bm_v  = rst_n && wb_vld && wb_wr && (wb_rd != 5'd0);
    if (wb_vld && wb_wr) begin bm_rd = wb_rd; bm_d = wb_res; end
    @(negedge clk);
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "u0 stall", {31'd0, s0}, {31'd0, e.es0});
        cmp(e.tag, "u1 stall", {31'd0, s1}, {31'd0, e.es1});
        if (!e.es0) begin
          cmp(e.tag, "u0 opa", a0, e.ea0);
          cmp(e.tag, "u0 opb", b0, e.eb0);
        end
        if (!e.es1) begin
          cmp(e.tag, "u1 opa", a1, e.ea1);
          cmp(e.tag, "u1 opb", b1, e.eb1);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    @(negedge clk);
    // R12: write presented during reset must not reach the buffer
    set_wb(5'd7, 32'h7777_7777);
    @(negedge clk);
    rst_n = 1'b1;
    bm_v = 1'b0;
    clr(); rs1_idx = 5'd7;
    step("R12 reset buffer empty");

    clr(); set_ex(5'd1, 1'b1, 32'hE000_0001);
    step("R4 ex forward / R10 disabled stall");
    clr(); set_ex(5'd1, 1'b0, 32'hE000_0002);
    step("R5 ex not ready");
    clr(); set_ex(5'd1, 1'b1, 32'hE000_0003); ex_vld = 1'b0;
    step("R3 ex invalid ignored");
    clr(); set_ex(5'd1, 1'b1, 32'hE000_0004); ex_wr = 1'b0;
    step("R3 ex no write ignored");
    clr(); set_ex(5'd1, 1'b0, 32'hE000_0005); rs1_used = 1'b0;
    step("R1 unused operand");
    clr(); rs1_idx = 5'd0; rf_rs1 = 32'hDEAD_BEEF; set_ex(5'd0, 1'b0, 32'hE000_0006);
    step("R2 x0 reads zero");
    clr(); set_mem(5'd2, 1'b1, 32'hA000_0001);
    step("R6 mem forward");
    clr(); set_mem(5'd2, 1'b0, 32'hA000_0002);
    step("R6 mem not ready");
    clr(); set_wb(5'd1, 32'hB000_0001);
    step("R7 wb forward");
    clr(); rs1_idx = 5'd3; set_wb(5'd9, 32'hB000_0009);
    step("R8 buffer fill");
    clr(); rs2_idx = 5'd9;
    step("R8 buffer forward");
    clr(); set_ex(5'd5, 1'b1, 32'hE000_0005); set_mem(5'd5, 1'b1, 32'hA000_0005);
    set_wb(5'd5, 32'hB000_0005); rs1_idx = 5'd5;
    step("R9 ex newest");
    clr(); set_mem(5'd5, 1'b1, 32'hA000_0015); set_wb(5'd5, 32'hB000_0015); rs1_idx = 5'd5;
    step("R9 mem over wb");
    clr(); set_ex(5'd5, 1'b0, 32'hE000_0025); set_mem(5'd5, 1'b1, 32'hA000_0025); rs1_idx = 5'd5;
    step("R9 not ready newest stalls");
    clr(); set_wb(5'd5, 32'hB000_0035); rs1_idx = 5'd5;
    step("R9 wb setup");
    clr(); set_wb(5'd5, 32'hB000_0045); rs1_idx = 5'd5;
    step("R9 wb over buffer");
    clr(); rs1_idx = 5'd3; set_mem(5'd2, 1'b0, 32'hA000_0055);
    step("R11 operand b alone stalls");
    clr(); set_ex(5'd1, 1'b1, 32'hE000_0065); set_mem(5'd2, 1'b1, 32'hA000_0065);
    step("R11 independent sources");
    clr(); rs1_idx = 5'd4; rs2_idx = 5'd6;
    step("R1 no producers");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule